// File: doc/BRIEF.md
# Shared Instruction Filter Cache

This block sits in the front end of a GPU streaming multiprocessor, between the warp scheduler and the instruction cache. It is a small set-associative table shared by all warps. Each entry keeps one 64-bit instruction and is tagged by its fetch PC. When many concurrent warps step through the same code, the first warp to fetch an instruction installs it. The other warps then read it from the table, and the larger instruction cache stays idle for those fetches.

A fetch is presented as a PC with a valid strobe. A hit answers on the next cycle with the stored instruction and the hit flag set. A miss lowers `req_ready` and raises a request to the instruction cache. The block waits for the single returned word, forwards it as the response with the hit flag clear, and writes it into a victim way chosen by least-recent use. A flush input empties the table in one cycle. Two free-running counters record accepted fetches and hits, so the hit rate can be read.

Top module: `insn_filter_cache`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, `req_ready`, `rsp_valid` and `ic_req_valid` are low and both counters read zero. After reset every entry is empty, so the first fetch of any PC misses.
- R2: The table holds `ENTRIES` instructions, 32 by default or 16 by parameter, in 4 ways. For the default the set index is PC[5:3] and the tag is PC[31:6]. PC[2:0] takes no part in lookup. Two PCs with the same set index and different tags never satisfy each other.
- R3: A fetch accepted while its PC is stored produces `rsp_valid` with `rsp_hit`=1 and the stored word on the next cycle, and it raises no instruction-cache request.
- R4: A fetch that misses drops `req_ready` and holds `ic_req_valid` high with `ic_req_pc` equal to the fetch PC until `ic_rsp_valid` arrives. On the next cycle `rsp_valid` rises with `rsp_hit`=0 and `rsp_insn` equal to the returned word, and `req_ready` is high again.
- R5: Every word returned for a miss is installed. A later fetch of that PC by any warp hits, and at most one way ever matches a lookup.
- R6: A fill goes to the lowest-numbered empty way of its set. If the set has no empty way, the fill replaces the least recently used way. Both hits and fills make the way they touch the most recently used way.
- R7: A flush empties every entry in one cycle. A fetch accepted in the same cycle as a flush is handled as a miss.
- R8: When a flush coincides with the returned word of a miss, the word is still sent as the response but is not installed.
- R9: `acc_count` increases by one for each accepted fetch, and `hit_count` increases by one for each accepted fetch that hits.
- R10: `ic_rsp_valid` has no effect while no miss is outstanding. No response is produced and no entry changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Empty the whole table |
| req_valid | input | 1 | Fetch request strobe |
| req_pc | input | PC_W | Fetch PC |
| req_ready | output | 1 | Block can accept a fetch |
| rsp_valid | output | 1 | Response strobe |
| rsp_insn | output | INSN_W | Fetched instruction |
| rsp_hit | output | 1 | Response came from the table |
| ic_req_valid | output | 1 | Miss request to the instruction cache |
| ic_req_pc | output | PC_W | PC of the outstanding miss |
| ic_rsp_valid | input | 1 | Instruction-cache word strobe |
| ic_rsp_insn | input | INSN_W | Instruction-cache word |
| acc_count | output | CNT_W | Accepted fetches |
| hit_count | output | CNT_W | Fetches served from the table |

## Verification
The properties assume that the instruction cache returns exactly one word per outstanding miss and that a requester holds `req_valid` and `req_pc` steady until `req_ready` accepts them. Stray cache words are allowed, and the properties expect them to be ignored. The bench's cache model answers only while `ic_req_valid` is high, with a latency of one to four cycles. It produces a stray word only when no miss is pending and no fetch is offered. Flushes are driven either alone, together with an accepted fetch, or in the exact cycle of a fill, so every combination the flush-priority rules cover is reached.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic {
    FC_IDLE = 1'b0,
    FC_WAIT = 1'b1
  } fc_state_e;
endpackage

// File: rtl/ifc_store.sv
module ifc_store #(
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 26,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [WAYS-1:0]   lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WAYS-1:0]   wr_way,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  output logic [WAYS-1:0]   wr_row_valid
);
  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAYS-1:0]   vld_d [SETS];
  logic [DATA_W-1:0] way_dat [WAYS];
  logic              any_vld;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [DATA_W-1:0] dat_q [SETS];
    logic              wr_here;
    assign wr_here = wr_en && wr_way[w];
    always_ff @(posedge clk) begin
      if (wr_here) begin
        tag_q[wr_idx] <= wr_tag;
        dat_q[wr_idx] <= wr_data;
      end
    end
    assign lk_hit[w]  = vld_q[lk_idx][w] && (tag_q[lk_idx] == lk_tag);
    assign way_dat[w] = lk_hit[w] ? dat_q[lk_idx] : '0;
  end

  always_comb begin
    lk_data = '0;
    for (int w = 0; w < WAYS; w++) lk_data = lk_data | way_dat[w];
  end

  always_comb begin
    for (int s = 0; s < SETS; s++) vld_d[s] = vld_q[s];
    if (wr_en) vld_d[wr_idx] = vld_q[wr_idx] | wr_way;
    if (flush) for (int s = 0; s < SETS; s++) vld_d[s] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    else        for (int s = 0; s < SETS; s++) vld_q[s] <= vld_d[s];
  end

  assign wr_row_valid = vld_q[wr_idx];

  always_comb begin
    any_vld = 1'b0;
    for (int s = 0; s < SETS; s++) any_vld = any_vld | (|vld_q[s]);
  end

  // R5
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !any_vld);
endmodule

// File: rtl/ifc_lru.sv
module ifc_lru #(
  parameter int SETS  = 8,
  parameter int WAYS  = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] t_idx,
  input  logic [WAYS-1:0]  t_way,
  input  logic [IDX_W-1:0] q_idx,
  output logic [WAYS-1:0]  q_old
);
  localparam int AGE_W = $clog2(WAYS);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [AGE_W-1:0] age_d [SETS][WAYS];
  logic [AGE_W-1:0] ref_age;

  always_comb begin
    ref_age = '0;
    for (int w = 0; w < WAYS; w++) if (t_way[w]) ref_age = age_q[t_idx][w];
  end

  always_comb begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) age_d[s][w] = age_q[s][w];
    if (touch) begin
      for (int w = 0; w < WAYS; w++) begin
        if (t_way[w])                        age_d[t_idx][w] = '0;
        else if (age_q[t_idx][w] < ref_age) age_d[t_idx][w] = age_q[t_idx][w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
    end else begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= age_d[s][w];
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_old
    assign q_old[w] = (age_q[q_idx][w] == AGE_MAX);
  end

  // R6
  lru_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(q_old));

  // R6
  touch_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch |-> $onehot(t_way));
endmodule

// File: rtl/ifc_stats.sv
module ifc_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_inc,
  input  logic             hit_inc,
  output logic [CNT_W-1:0] acc_cnt,
  output logic [CNT_W-1:0] hit_cnt
);
  logic [CNT_W-1:0] acc_d, hit_d;

  always_comb begin
    acc_d = acc_cnt + CNT_W'(1);
    hit_d = hit_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_cnt <= '0;
    else if (acc_inc) acc_cnt <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hit_cnt <= '0;
    else if (hit_inc) hit_cnt <= hit_d;
  end

  // R9
  hit_is_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_inc |-> acc_inc);

  // R9
  acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_inc |=> $stable(acc_cnt));
endmodule

// File: rtl/insn_filter_cache.sv
module insn_filter_cache #(
  parameter int ENTRIES = 32,
  parameter int WAYS    = 4,
  parameter int PC_W    = 32,
  parameter int INSN_W  = 64,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [PC_W-1:0]   req_pc,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [INSN_W-1:0] rsp_insn,
  output logic              rsp_hit,
  output logic              ic_req_valid,
  output logic [PC_W-1:0]   ic_req_pc,
  input  logic              ic_rsp_valid,
  input  logic [INSN_W-1:0] ic_rsp_insn,
  output logic [CNT_W-1:0]  acc_count,
  output logic [CNT_W-1:0]  hit_count
);
  import ifc_pkg::*;

  localparam int SETS  = ENTRIES / WAYS;
  localparam int IDX_W = $clog2(SETS);
  localparam int OFF_W = $clog2(INSN_W / 8);
  localparam int TAG_W = PC_W - OFF_W - IDX_W;

  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  fc_state_e         state_q, state_d;
  logic [PC_W-1:0]   pend_q;
  logic              rsp_v_d, rsp_hit_d, rsp_en;
  logic [INSN_W-1:0] rsp_insn_d;

  logic [IDX_W-1:0]  lk_idx, pend_idx;
  logic [TAG_W-1:0]  lk_tag, pend_tag;
  logic [WAYS-1:0]   lk_hit, row_vld, q_old, vict, t_way;
  logic [INSN_W-1:0] lk_data;
  logic              accept, hit_any, is_hit, is_miss, fill_arrive, fill_en, touch, found;
  logic [IDX_W-1:0]  t_idx;
  logic              unused_lowbits;

  assign lk_idx   = req_pc[OFF_W +: IDX_W];
  assign lk_tag   = req_pc[PC_W-1 -: TAG_W];
  assign pend_idx = pend_q[OFF_W +: IDX_W];
  assign pend_tag = pend_q[PC_W-1 -: TAG_W];
  assign unused_lowbits = &{1'b0, req_pc[OFF_W-1:0]};

  assign req_ready   = rst_sync_n && (state_q == FC_IDLE);
  assign accept      = req_valid && req_ready;
  assign hit_any     = (|lk_hit) && !flush;
  assign is_hit      = accept && hit_any;
  assign is_miss     = accept && !hit_any;
  assign fill_arrive = (state_q == FC_WAIT) && ic_rsp_valid;
  assign fill_en     = fill_arrive && !flush;

  always_comb begin
    vict  = '0;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !row_vld[w]) begin
        vict[w] = 1'b1;
        found   = 1'b1;
      end
    end
    if (!found) vict = q_old;
  end

  assign touch = is_hit || fill_en;
  assign t_idx = is_hit ? lk_idx : pend_idx;
  assign t_way = is_hit ? lk_hit : vict;

  always_comb begin
    state_d    = state_q;
    rsp_v_d    = 1'b0;
    rsp_hit_d  = 1'b0;
    rsp_insn_d = ic_rsp_insn;
    case (state_q)
      FC_IDLE: begin
        if (is_hit) begin
          rsp_v_d    = 1'b1;
          rsp_hit_d  = 1'b1;
          rsp_insn_d = lk_data;
        end else if (is_miss) begin
          state_d = FC_WAIT;
        end
      end
      FC_WAIT: begin
        if (ic_rsp_valid) begin
          rsp_v_d = 1'b1;
          state_d = FC_IDLE;
        end
      end
      default: state_d = FC_IDLE;
    endcase
  end
  assign rsp_en = rsp_v_d;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= FC_IDLE;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= rsp_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (is_miss) pend_q <= req_pc;
  end

  always_ff @(posedge clk) begin
    if (rsp_en) begin
      rsp_hit  <= rsp_hit_d;
      rsp_insn <= rsp_insn_d;
    end
  end

  assign ic_req_valid = (state_q == FC_WAIT);
  assign ic_req_pc    = pend_q;

  ifc_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(INSN_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .flush(flush),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_data(lk_data),
    .wr_en(fill_en), .wr_idx(pend_idx), .wr_way(vict), .wr_tag(pend_tag),
    .wr_data(ic_rsp_insn), .wr_row_valid(row_vld)
  );

  ifc_lru #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_sync_n), .touch(touch), .t_idx(t_idx), .t_way(t_way),
    .q_idx(pend_idx), .q_old(q_old)
  );

  ifc_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_sync_n), .acc_inc(accept), .hit_inc(is_hit),
    .acc_cnt(acc_count), .hit_cnt(hit_count)
  );

  // R4
  miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ic_req_valid |-> !req_ready);

  // R3
  hit_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    is_hit |=> rsp_valid && rsp_hit && !ic_req_valid);

  // R4
  fill_forward_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ic_req_valid && ic_rsp_valid) |=>
      rsp_valid && !rsp_hit && req_ready && (rsp_insn == $past(ic_rsp_insn)));

  // R10
  stray_word_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ic_req_valid && ic_rsp_valid && !req_valid) |=> !rsp_valid);
endmodule

// File: tb/insn_filter_cache_test.sv
module insn_filter_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETS  = 8;
  localparam int WAYS  = 4;
  localparam int IDXW  = 3;
  localparam int LIMIT = 150000;

  logic        clk, rst_n, flush, flush_drv, ff_flush;
  logic        req_valid, req_ready, rsp_valid, rsp_hit, ic_req_valid, ic_rsp_valid;
  logic [31:0] req_pc, ic_req_pc, acc_count, hit_count;
  logic [63:0] rsp_insn, ic_rsp_insn;

  assign flush = flush_drv | ff_flush;

  insn_filter_cache uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_pc(req_pc),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_insn(rsp_insn), .rsp_hit(rsp_hit),
    .ic_req_valid(ic_req_valid), .ic_req_pc(ic_req_pc), .ic_rsp_valid(ic_rsp_valid),
    .ic_rsp_insn(ic_rsp_insn), .acc_count(acc_count), .hit_count(hit_count)
  );

  int n_chk = 0, n_fail = 0, n_req = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [63:0] ic_word(input logic [31:0] pc);
    return {pc ^ 32'h5A5A_C3C3, pc * 32'h9E37_79B1};
  endfunction

  // ---------------- reference model ----------------
  bit          m_vld [SETS][WAYS];
  int unsigned m_tag [SETS][WAYS];
  logic [63:0] m_dat [SETS][WAYS];
  int          m_age [SETS][WAYS];
  int          m_state;
  logic [31:0] m_pc;
  bit          m_rv, m_rh, m_rs1, m_rs2;
  logic [63:0] m_ri;
  int unsigned m_acc, m_hit;

  function automatic int m_set(input logic [31:0] pc);
    return int'((pc >> 3) % SETS);
  endfunction
  function automatic int unsigned m_tagof(input logic [31:0] pc);
    return pc >> (3 + IDXW);
  endfunction

  task automatic m_touch(input int s, input int w);
    int r;
    r = m_age[s][w];
    for (int v = 0; v < WAYS; v++) begin
      if (v == w) m_age[s][v] = 0;
      else if (m_age[s][v] < r) m_age[s][v]++;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin : model
    int s, hw, vw;
    if (!rst_n) begin
      for (int a = 0; a < SETS; a++)
        for (int b = 0; b < WAYS; b++) begin
          m_vld[a][b] = 0;
          m_age[a][b] = b;
        end
      m_state = 0; m_rv = 0; m_acc = 0; m_hit = 0; m_rs1 = 0; m_rs2 = 0;
    end else if (!m_rs2) begin
      m_rs2 = m_rs1;
      m_rs1 = 1;
    end else begin
      m_rv = 0;
      if (m_state == 0 && req_valid) begin
        m_acc++;
        s = m_set(req_pc);
        hw = -1;
        for (int b = 0; b < WAYS; b++)
          if (m_vld[s][b] && m_tag[s][b] == m_tagof(req_pc)) hw = b;
        if (hw >= 0 && !flush) begin
          m_hit++; m_rv = 1; m_rh = 1; m_ri = m_dat[s][hw];
          m_touch(s, hw);
        end else begin
          m_state = 1; m_pc = req_pc;
        end
      end else if (m_state == 1 && ic_rsp_valid) begin
        m_rv = 1; m_rh = 0; m_ri = ic_rsp_insn; m_state = 0;
        if (!flush) begin
          s = m_set(m_pc);
          vw = -1;
          for (int b = 0; b < WAYS; b++) if (vw < 0 && !m_vld[s][b]) vw = b;
          if (vw < 0) for (int b = 0; b < WAYS; b++) if (m_age[s][b] == WAYS - 1) vw = b;
          m_vld[s][vw] = 1; m_tag[s][vw] = m_tagof(m_pc); m_dat[s][vw] = ic_rsp_insn;
          m_touch(s, vw);
        end
      end
      if (flush)
        for (int a = 0; a < SETS; a++)
          for (int b = 0; b < WAYS; b++) m_vld[a][b] = 0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready === (m_rs2 && m_state == 0), "R4 req_ready", 64'(req_ready), 64'(m_rs2 && m_state == 0));
      chk(ic_req_valid === (m_state == 1), "R4 ic_req_valid", 64'(ic_req_valid), 64'(m_state == 1));
      if (m_state == 1) chk(ic_req_pc === m_pc, "R4 ic_req_pc", 64'(ic_req_pc), 64'(m_pc));
      chk(rsp_valid === m_rv, "R3 rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) begin
        chk(rsp_hit === m_rh, m_rh ? "R3 rsp_hit" : "R4 rsp_hit", 64'(rsp_hit), 64'(m_rh));
        chk(rsp_insn === m_ri, m_rh ? "R3 rsp_insn" : "R4 rsp_insn", rsp_insn, m_ri);
      end
      chk(acc_count === m_acc, "R9 acc_count", 64'(acc_count), 64'(m_acc));
      chk(hit_count === m_hit, "R9 hit_count", 64'(hit_count), 64'(m_hit));
    end
  end

  // ---------------- instruction cache model ----------------
  int ic_lat = 1, ic_cnt = 0, stray_req = 0, stray_ack = 0;
  bit ic_busy = 0, flush_on_fill = 0;

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ic_rsp_valid = 0; ic_rsp_insn = '0; ic_busy = 0; ff_flush = 0;
    end else begin
      ff_flush = 0;
      if (ic_rsp_valid) begin
        ic_rsp_valid = 0;
        ic_busy = 0;
      end else if (stray_req != stray_ack && !ic_req_valid && !ic_busy) begin
        stray_ack = stray_req;
        ic_rsp_valid = 1;
        ic_rsp_insn = 64'hBAD0_BAD0_BAD0_BAD0;
      end else if (ic_req_valid) begin
        if (!ic_busy) begin
          ic_busy = 1;
          ic_cnt = ic_lat;
        end
        if (ic_cnt <= 1) begin
          ic_rsp_valid = 1;
          ic_rsp_insn = ic_word(ic_req_pc);
          if (flush_on_fill) ff_flush = 1;
        end else ic_cnt--;
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic probe(input logic [31:0] pc, input int exp_hit, input string tag, input bit with_flush);
    bit acc;
    req_valid = 1; req_pc = pc; flush_drv = with_flush;
    do begin
      acc = req_ready;
      @(negedge clk);
    end while (!acc);
    req_valid = 0; flush_drv = 0;
    n_req++;
    while (!rsp_valid) @(negedge clk);
    if (exp_hit >= 0) chk(rsp_hit === exp_hit[0], tag, 64'(rsp_hit), 64'(exp_hit));
  endtask

  task automatic pulse_flush();
    flush_drv = 1;
    @(negedge clk);
    flush_drv = 0;
  endtask

  initial begin
    rst_n = 0; flush_drv = 0; req_valid = 0; req_pc = '0;
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 rsp_valid in reset", 64'(rsp_valid), 0);
    chk(req_ready === 1'b0, "R1 req_ready in reset", 64'(req_ready), 0);
    chk(ic_req_valid === 1'b0, "R1 ic_req_valid in reset", 64'(ic_req_valid), 0);
    chk(acc_count === 0 && hit_count === 0, "R1 counters in reset", 64'(acc_count), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    probe(32'h0000_0040, 0, "R1 empty after reset", 0);

    // many warps in round-robin over one code block
    for (int i = 0; i < 16; i++)
      for (int w = 0; w < 8; w++)
        probe(32'h0000_1000 + 32'(i * 8), (w == 0) ? 0 : 1,
              (w == 0) ? "R5 first warp misses" : "R5 other warp hits", 0);

    probe(32'h0000_1004, 1, "R2 low PC bits ignored", 0);
    probe(32'h0000_1200, 0, "R2 same set other tag misses", 0);

    // replacement order in set 0
    pulse_flush();
    ic_lat = 2;
    for (int k = 0; k < 4; k++) probe(32'h0001_0000 + 32'(k * 64), 0, "R6 fill empty way", 0);
    probe(32'h0001_0000, 1, "R6 hit k0", 0);
    probe(32'h0001_0100, 0, "R6 fifth tag misses", 0);
    probe(32'h0001_0000, 1, "R6 recently used kept", 0);
    probe(32'h0001_0040, 0, "R6 least recent evicted", 0);
    probe(32'h0001_0000, 1, "R6 k0 still present", 0);
    probe(32'h0001_00C0, 1, "R6 k3 still present", 0);
    probe(32'h0001_0100, 1, "R6 k4 still present", 0);
    probe(32'h0001_0080, 0, "R6 second victim", 0);

    // flush behaviour
    probe(32'h0000_3000, -1, "", 0);
    pulse_flush();
    probe(32'h0000_3000, 0, "R7 flush empties table", 0);
    probe(32'h0000_3000, 1, "R7 refill hits", 0);
    probe(32'h0000_3000, 0, "R7 same-cycle flush forces miss", 1);
    probe(32'h0000_3000, 1, "R7 fill after flush cycle installs", 0);

    // flush in the fill cycle
    flush_on_fill = 1;
    probe(32'h0000_5000, 0, "R8 miss with flush at fill", 0);
    flush_on_fill = 0;
    chk(rsp_insn === ic_word(32'h0000_5000), "R8 word still returned", rsp_insn, ic_word(32'h0000_5000));
    probe(32'h0000_5000, 0, "R8 word not installed", 0);

    // stray cache word while idle
    probe(32'h0000_5000, 1, "R10 entry before stray word", 0);
    stray_req++;
    repeat (4) begin
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R10 stray word gives no response", 64'(rsp_valid), 0);
    end
    probe(32'h0000_5000, 1, "R10 entry intact after stray word", 0);

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      ic_lat = 1 + int'($urandom % 4);
      probe(32'h0002_0000 + 32'(($urandom % 48) * 8), -1, "", ($urandom % 50) == 0);
      if (($urandom % 8) == 0) @(negedge clk);
    end

    repeat (3) @(negedge clk);
    chk(acc_count === 32'(n_req), "R9 accepted fetch total", 64'(acc_count), 64'(n_req));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule